// File: doc/BRIEF.md
# Multiplexed Bus Address Demultiplexer and Strobe Decoder

This glue block sits between a processor that shares its low address byte with its data lines and the memory and peripherals behind it. In the first period of a bus cycle the processor drives the low address byte on the shared lines and raises an address-strobe enable. In the second period the shared lines turn over to data. The block captures the low byte while the enable is high and holds it after the enable falls. It joins that byte to the upper address byte, which the processor keeps valid for the whole cycle. The result is a full address that stays stable through all three periods of the cycle.

The processor gives only one read strobe and one write strobe, plus a space-select line: low for memory, high for I/O. The block splits these into four active-low strobes: memory read, memory write, I/O read and I/O write. At most one of the four is ever asserted. If both input strobes are low at once, which is an illegal request, all four outputs stay inactive.

The capture register is clocked by the processor clock. While the enable is high, the low byte is passed straight through with no register in the path. The strobe decode is purely combinational.

Top module: `addr_strobe_demux`

## Requirements
- R1: While `ale_i` is high, `addr_o[7:0]` equals `ad_i` in the same cycle.
- R2: Once `ale_i` is low, `addr_o[7:0]` holds the value `ad_i` had at the last rising clock edge at which `ale_i` was high. It ignores any later change on `ad_i` until `ale_i` rises again.
- R3: `addr_o[15:8]` always equals `addr_hi_i`.
- R4: After reset, while `ale_i` is low and has not yet been high, `addr_o[7:0]` is 0.
- R5: With `io_m_i`=0, `rd_n_i`=0 and `wr_n_i`=1, only `mem_rd_n_o` is low.
- R6: With `io_m_i`=1, `rd_n_i`=0 and `wr_n_i`=1, only `io_rd_n_o` is low.
- R7: With `io_m_i`=0, `wr_n_i`=0 and `rd_n_i`=1, only `mem_wr_n_o` is low.
- R8: With `io_m_i`=1, `wr_n_i`=0 and `rd_n_i`=1, only `io_wr_n_o` is low.
- R9: With `rd_n_i`=1 and `wr_n_i`=1, all four output strobes are high, whatever the value of `io_m_i`.
- R10: With `rd_n_i`=0 and `wr_n_i`=0 together, all four output strobes are high.
- R11: At no time is more than one of the four output strobes low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock; the capture register is updated on its rising edge |
| rst_n | input | 1 | Active-low reset; clears the held low byte |
| ad_i | input | 8 | Shared low-address / data lines |
| addr_hi_i | input | 8 | Upper address byte |
| ale_i | input | 1 | Address-strobe enable; high while `ad_i` carries an address |
| io_m_i | input | 1 | Space select: 0 = memory, 1 = I/O |
| rd_n_i | input | 1 | Shared read strobe, active low |
| wr_n_i | input | 1 | Shared write strobe, active low |
| addr_o | output | 16 | Full demultiplexed address |
| mem_rd_n_o | output | 1 | Memory read strobe, active low |
| mem_wr_n_o | output | 1 | Memory write strobe, active low |
| io_rd_n_o | output | 1 | I/O read strobe, active low |
| io_wr_n_o | output | 1 | I/O write strobe, active low |

## Verification
A wrong held low byte becomes visible on `addr_o[7:0]` in the first cycle after the enable falls. In that cycle the shared lines already carry data, so the bench drives data bytes that differ from the address, and a bad capture shows as the data byte or as a stale address. A missed update shows one bus cycle later, as the previous cycle's low byte. The strobe decode has no state, so any error in it appears at once, in the same cycle as the input pattern that exposes it. The illegal both-strobes-low pattern and the idle pattern are each applied under both space-select values.

// File: rtl/addr_strobe_pkg.sv
package addr_strobe_pkg;

  // Active-low strobe bundle, one bit per target space/direction.
  typedef struct packed {
    logic mem_rd_n;
    logic mem_wr_n;
    logic io_rd_n;
    logic io_wr_n;
  } strobe_t;

  localparam strobe_t STROBES_IDLE = '{mem_rd_n: 1'b1, mem_wr_n: 1'b1,
                                       io_rd_n: 1'b1, io_wr_n: 1'b1};

  // Split the shared read/write strobes by address space.
  // A simultaneous read and write request is suppressed entirely.
  function automatic strobe_t split_strobes(input logic rd_n,
                                            input logic wr_n,
                                            input logic io_sel);
    strobe_t s;
    logic    rd_req;
    logic    wr_req;
    s      = STROBES_IDLE;
    rd_req = !rd_n && wr_n;
    wr_req = !wr_n && rd_n;
    s.mem_rd_n = !(rd_req && !io_sel);
    s.io_rd_n  = !(rd_req &&  io_sel);
    s.mem_wr_n = !(wr_req && !io_sel);
    s.io_wr_n  = !(wr_req &&  io_sel);
    return s;
  endfunction

  // Number of strobes currently asserted (low).
  function automatic int unsigned active_strobes(input strobe_t s);
    return int'(!s.mem_rd_n) + int'(!s.mem_wr_n) +
           int'(!s.io_rd_n)  + int'(!s.io_wr_n);
  endfunction

endpackage

// File: rtl/addr_lo_capture.sv
module addr_lo_capture #(
  parameter int LO_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ale,
  input  logic [LO_W-1:0] ad,
  output logic [LO_W-1:0] lo_o,
  output logic [LO_W-1:0] held_q,
  output logic            load_evt
);

  // A load event happens on every rising edge that sees the enable high.
  assign load_evt = ale;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (load_evt) begin
      held_q <= ad;
    end
  end

  // Transparent while the enable is high, held copy otherwise.
  assign lo_o = ale ? ad : held_q;

endmodule

// File: rtl/strobe_split.sv
module strobe_split
  import addr_strobe_pkg::*;
(
  input  logic    rd_n,
  input  logic    wr_n,
  input  logic    io_sel,
  output strobe_t strobes,
  output logic    conflict
);

  assign conflict = !rd_n && !wr_n;
  assign strobes  = split_strobes(rd_n, wr_n, io_sel);

endmodule

// File: rtl/addr_strobe_demux.sv
module addr_strobe_demux
  import addr_strobe_pkg::*;
#(
  parameter int LO_W = 8,
  parameter int HI_W = 8,
  localparam int ADDR_W = LO_W + HI_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LO_W-1:0]   ad_i,
  input  logic [HI_W-1:0]   addr_hi_i,
  input  logic              ale_i,
  input  logic              io_m_i,
  input  logic              rd_n_i,
  input  logic              wr_n_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              mem_rd_n_o,
  output logic              mem_wr_n_o,
  output logic              io_rd_n_o,
  output logic              io_wr_n_o
);

  // Internal events brought out by name for the bound checker.
  logic [LO_W-1:0] lo_byte;
  logic [LO_W-1:0] lo_held;
  logic            lo_load;
  logic            strobe_conflict;
  strobe_t         strobes;

  addr_lo_capture #(.LO_W(LO_W)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .ale      (ale_i),
    .ad       (ad_i),
    .lo_o     (lo_byte),
    .held_q   (lo_held),
    .load_evt (lo_load)
  );

  strobe_split u_split (
    .rd_n     (rd_n_i),
    .wr_n     (wr_n_i),
    .io_sel   (io_m_i),
    .strobes  (strobes),
    .conflict (strobe_conflict)
  );

  assign addr_o     = {addr_hi_i, lo_byte};
  assign mem_rd_n_o = strobes.mem_rd_n;
  assign mem_wr_n_o = strobes.mem_wr_n;
  assign io_rd_n_o  = strobes.io_rd_n;
  assign io_wr_n_o  = strobes.io_wr_n;

endmodule

// File: rtl/addr_strobe_demux_chk.sv
module addr_strobe_demux_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [LO_W-1:0]      ad_i,
  input logic [HI_W-1:0]      addr_hi_i,
  input logic                 ale_i,
  input logic                 io_m_i,
  input logic                 rd_n_i,
  input logic                 wr_n_i,
  input logic [LO_W+HI_W-1:0] addr_o,
  input logic                 mem_rd_n_o,
  input logic                 mem_wr_n_o,
  input logic                 io_rd_n_o,
  input logic                 io_wr_n_o,
  input logic                 lo_load,
  input logic                 strobe_conflict
);

  logic [3:0] stb_n;
  assign stb_n = {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o};

  AST_LO_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    ale_i |-> addr_o[LO_W-1:0] == ad_i);                                   // R1

  AST_LO_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ale_i) && $past(rst_n) && $past(lo_load))
      |-> addr_o[LO_W-1:0] == $past(ad_i));                                // R2

  AST_LO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ale_i && !$past(ale_i) && $past(rst_n))
      |-> $stable(addr_o[LO_W-1:0]));                                      // R2

  AST_HI_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    addr_o[LO_W+HI_W-1:LO_W] == addr_hi_i);                                // R3

  AST_MEM_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i && wr_n_i && !io_m_i) |-> stb_n == 4'b0111);                  // R5

  AST_IO_RD: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n_i && wr_n_i && io_m_i) |-> stb_n == 4'b1101);                   // R6

  AST_MEM_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i && !wr_n_i && !io_m_i) |-> stb_n == 4'b1011);                  // R7

  AST_IO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i && !wr_n_i && io_m_i) |-> stb_n == 4'b1110);                   // R8

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n_i && wr_n_i) |-> stb_n == 4'b1111);                              // R9

  AST_CONFLICT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_conflict |-> stb_n == 4'b1111);                                 // R10

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~stb_n) <= 1);                                              // R11

endmodule

bind addr_strobe_demux addr_strobe_demux_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .ad_i            (ad_i),
  .addr_hi_i       (addr_hi_i),
  .ale_i           (ale_i),
  .io_m_i          (io_m_i),
  .rd_n_i          (rd_n_i),
  .wr_n_i          (wr_n_i),
  .addr_o          (addr_o),
  .mem_rd_n_o      (mem_rd_n_o),
  .mem_wr_n_o      (mem_wr_n_o),
  .io_rd_n_o       (io_rd_n_o),
  .io_wr_n_o       (io_wr_n_o),
  .lo_load         (lo_load),
  .strobe_conflict (strobe_conflict)
);

// File: tb/sim_addr_strobe_demux.sv
module sim_addr_strobe_demux;

  typedef struct {
    logic [15:0] addr;
    logic [3:0]  stb;   // {mem_rd_n, mem_wr_n, io_rd_n, io_wr_n}
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ad_i = '0;
  logic [7:0]  addr_hi_i = '0;
  logic        ale_i = 1'b0;
  logic        io_m_i = 1'b0;
  logic        rd_n_i = 1'b1;
  logic        wr_n_i = 1'b1;
  logic [15:0] addr_o;
  logic        mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o;

  int   n_checks = 0;
  int   n_fails  = 0;
  exp_t sb[$];
  logic [7:0] mdl_lo = '0;
  bit   done = 1'b0;

  always #10 clk = ~clk;   // 50 MHz

  addr_strobe_demux u0 (
    .clk(clk), .rst_n(rst_n), .ad_i(ad_i), .addr_hi_i(addr_hi_i),
    .ale_i(ale_i), .io_m_i(io_m_i), .rd_n_i(rd_n_i), .wr_n_i(wr_n_i),
    .addr_o(addr_o), .mem_rd_n_o(mem_rd_n_o), .mem_wr_n_o(mem_wr_n_o),
    .io_rd_n_o(io_rd_n_o), .io_wr_n_o(io_wr_n_o)
  );

  function automatic logic [3:0] model_strobes(logic rd_n, logic wr_n, logic io_sel);
    logic [3:0] e = 4'b1111;
    case ({rd_n, wr_n})
      2'b01:   e[io_sel ? 1 : 3] = 1'b0;   // read only
      2'b10:   e[io_sel ? 0 : 2] = 1'b0;   // write only
      default: e = 4'b1111;                // idle or conflict
    endcase
    return e;
  endfunction

  // Driver: apply one cycle of bus inputs and push the expected outputs.
  task automatic step(input logic [7:0] ad, input logic [7:0] hi, input logic ale,
                      input logic iom, input logic rd_n, input logic wr_n,
                      input string tag);
    exp_t e;
    @(negedge clk);
    ad_i = ad; addr_hi_i = hi; ale_i = ale; io_m_i = iom;
    rd_n_i = rd_n; wr_n_i = wr_n;
    e.addr = {hi, (ale ? ad : mdl_lo)};
    e.stb  = model_strobes(rd_n, wr_n, iom);
    e.tag  = tag;
    sb.push_back(e);
    @(posedge clk);
    if (ale) mdl_lo = ad;
  endtask

  // Monitor: compare mid low phase, well away from the rising edge.
  initial begin
    forever begin
      @(negedge clk);
      #4;
      while (sb.size() > 0) begin
        exp_t e;
        logic [3:0] got;
        e   = sb.pop_front();
        got = {mem_rd_n_o, mem_wr_n_o, io_rd_n_o, io_wr_n_o};
        n_checks++;
        if (addr_o !== e.addr) begin
          n_fails++;
          $display("FAIL %s addr: actual %h expected %h", e.tag, addr_o, e.addr);
        end
        n_checks++;
        if (got !== e.stb) begin
          n_fails++;
          $display("FAIL %s strobes: actual %b expected %b", e.tag, got, e.stb);
        end
        n_checks++;
        if ($countones(~got) > 1) begin
          n_fails++;
          $display("FAIL R11 strobes: actual %b expected at most one low", got);
        end
      end
    end
  end

  initial begin
    #4_000_000;
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(8'h5A, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, "R4 reset low byte");
    @(negedge clk); rst_n = 1'b1;
    step(8'hC3, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, "R4 after reset");
    // Memory read cycle at 0x2005
    step(8'h05, 8'h20, 1'b1, 1'b0, 1'b1, 1'b1, "R1 R9 mem rd T1");
    step(8'hAA, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, "R2 R5 mem rd T2");
    step(8'h3C, 8'h20, 1'b0, 1'b0, 1'b0, 1'b1, "R2 R5 mem rd T3");
    step(8'hFF, 8'h20, 1'b0, 1'b0, 1'b1, 1'b1, "R2 R9 after rd");
    // I/O write to 0x4081
    step(8'h81, 8'h40, 1'b1, 1'b1, 1'b1, 1'b1, "R1 R3 io wr T1");
    step(8'h11, 8'h40, 1'b0, 1'b1, 1'b1, 1'b0, "R2 R8 io wr T2");
    step(8'h22, 8'h40, 1'b0, 1'b1, 1'b1, 1'b0, "R2 R8 io wr T3");
    // I/O read from 0x9F7E
    step(8'h7E, 8'h9F, 1'b1, 1'b1, 1'b1, 1'b1, "R1 io rd T1");
    step(8'h00, 8'h9F, 1'b0, 1'b1, 1'b0, 1'b1, "R2 R6 io rd T2");
    step(8'hE7, 8'h9F, 1'b0, 1'b1, 1'b0, 1'b1, "R2 R6 io rd T3");
    // Memory write, enable held two cycles with changing lines
    step(8'h10, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, "R1 long ale a");
    step(8'hF0, 8'hFF, 1'b1, 1'b0, 1'b1, 1'b1, "R1 long ale b");
    step(8'h0F, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b0, "R2 R7 mem wr T2");
    step(8'h55, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, "R3 R7 mem wr hi change");
    // Idle under both spaces, conflict under both spaces
    step(8'h99, 8'h12, 1'b0, 1'b1, 1'b1, 1'b1, "R9 idle io");
    step(8'h66, 8'h12, 1'b0, 1'b0, 1'b1, 1'b1, "R9 idle mem");
    step(8'h44, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, "R10 conflict mem");
    step(8'h33, 8'h12, 1'b0, 1'b1, 1'b0, 1'b0, "R10 conflict io");
    step(8'h33, 8'h12, 1'b0, 1'b1, 1'b1, 1'b1, "R9 end idle");
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule